// File: doc/BRIEF.md
# Saturating Fixed-Point Multiply-Accumulate Element

This block is one processing element of a fully connected layer. It produces a single neuron output. A clear strobe seeds a 32-bit accumulator with the neuron's bias. Each cycle with the accumulate enable high, it adds the product of a signed 16-bit input and a signed 16-bit weight to the accumulator. A commit strobe reduces the running sum to a registered 16-bit result. Values outside the 16-bit range are clamped, and a rectifier can be switched on per layer so that negative results become zero.

Values are signed fixed point, with the number of fractional bits set by a parameter (default 8). The full product is shifted right arithmetically by that many bits before it is added, so the accumulator stays at the same scale as the bias and the output. The accumulator is sign-extended and wraps silently. Range checking happens only when the result is committed. Feeding weights and inputs, and the order in which they arrive, belong to the surrounding controller.

Top module: `sat_mac_cell`

## Requirements
- R1: After reset the accumulator is zero and both `y_o` and `y_valid_o` are zero.
- R2: A cycle with `clr_i` high loads the sign-extended `bias_i` into the accumulator and discards any earlier sum. `clr_i` takes priority over `acc_en_i` in the same cycle.
- R3: A cycle with `acc_en_i` high (and `clr_i` low) adds (`x_i` * `w_i`) arithmetically shifted right by FRAC bits (floor toward minus infinity) to the accumulator. With `acc_en_i` low, `x_i` and `w_i` have no effect.
- R4: The 32-bit accumulator wraps modulo 2^32 on overflow. No clamping happens inside it.
- R5: `y_valid_o` is high exactly in the cycle after each cycle with `commit_i` high, and low otherwise. `y_o` changes only on commit.
- R6: On commit, an accumulator value within [-32768, 32767] appears unchanged on `y_o` when the rectifier is off.
- R7: On commit, an accumulator value above 32767 gives `y_o` = 16'h7FFF.
- R8: On commit, an accumulator value below -32768 gives `y_o` = 16'h8000.
- R9: With `relu_en_i` high at commit, a negative clamped result gives `y_o` = 0 and a non-negative result passes unchanged. The rectifier acts after clamping.
- R10: Commit reads the accumulator as it stands before that cycle's clear or accumulate, and commit does not change the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Load bias into accumulator |
| bias_i | input | 16 | Signed bias, same scale as output |
| acc_en_i | input | 1 | Add scaled product this cycle |
| x_i | input | 16 | Signed input value |
| w_i | input | 16 | Signed weight |
| commit_i | input | 1 | Capture clamped result into output |
| relu_en_i | input | 1 | Zero negative results at commit |
| y_o | output | 16 | Registered neuron output |
| y_valid_o | output | 1 | Output updated in previous cycle |

## Verification
The hardest state to reach from the ports is a wrap of the accumulator. The largest scaled product is 2^22, so only a long run of accumulations pushes the sum past 2^31.

The bench seeds the bias at 32767 and accumulates the most negative input times the most negative weight 511 times. Committing there must still clamp high. One more accumulation pushes the sum over the 2^31 boundary, and the next commit must clamp low. This shows that the sum wrapped rather than saturated.

Exact boundary values (32767, 32768, -32768, -32769) and rounding of negative products are reached with small tailored biases and unit products.

// File: rtl/sat_mac_cell.sv
module sat_mac_cell #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 32,
  parameter int FRAC   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] bias_i,
  input  logic              acc_en_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] w_i,
  input  logic              commit_i,
  input  logic              relu_en_i,
  output logic [DATA_W-1:0] y_o,
  output logic              y_valid_o
);
  localparam int PROD_W = 2 * DATA_W;
  localparam logic signed [ACC_W-1:0] SAT_HI = {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] SAT_LO = {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  logic signed [PROD_W-1:0] prod, prod_sc;
  logic signed [ACC_W-1:0]  prod_ext, bias_ext, acc_q;
  logic        [DATA_W-1:0] clamped, shaped;

  assign prod     = $signed(x_i) * $signed(w_i);
  assign prod_sc  = prod >>> FRAC;
  assign prod_ext = ACC_W'(prod_sc);
  assign bias_ext = ACC_W'($signed(bias_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        acc_q <= '0;
    else if (clr_i)    acc_q <= bias_ext;
    else if (acc_en_i) acc_q <= acc_q + prod_ext;
  end

  always_comb begin
    if (acc_q > SAT_HI)      clamped = SAT_HI[DATA_W-1:0];
    else if (acc_q < SAT_LO) clamped = SAT_LO[DATA_W-1:0];
    else                     clamped = acc_q[DATA_W-1:0];
  end

  assign shaped = (relu_en_i && clamped[DATA_W-1]) ? '0 : clamped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_o       <= '0;
      y_valid_o <= 1'b0;
    end else begin
      y_valid_o <= commit_i;
      if (commit_i) y_o <= shaped;
    end
  end
endmodule

// File: rtl/sat_mac_cell_chk.sv
module sat_mac_cell_chk #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_i,
  input logic [DATA_W-1:0] bias_i,
  input logic              commit_i,
  input logic              relu_en_i,
  input logic [ACC_W-1:0]  acc_q,
  input logic [DATA_W-1:0] y_o,
  input logic              y_valid_o
);
  localparam logic signed [ACC_W-1:0] MAXV = {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] MINV = {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  logic signed [ACC_W-1:0] bias_wide;
  assign bias_wide = ACC_W'($signed(bias_i));

  AST_CLEAR_LOADS_BIAS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> acc_q == $past(bias_wide));  // R2
  AST_VALID_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |=> y_valid_o);  // R5
  AST_NO_VALID_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> !y_valid_o);  // R5
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(y_o));  // R5
  AST_PASS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && !relu_en_i && $signed(acc_q) <= MAXV && $signed(acc_q) >= MINV)
      |=> y_o == $past(acc_q[DATA_W-1:0]));  // R6
  AST_CLAMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && $signed(acc_q) > MAXV) |=> y_o == MAXV[DATA_W-1:0]);  // R7
  AST_CLAMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && !relu_en_i && $signed(acc_q) < MINV) |=> y_o == MINV[DATA_W-1:0]);  // R8
  AST_RELU_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && relu_en_i) |=> !y_o[DATA_W-1]);  // R9
endmodule

bind sat_mac_cell sat_mac_cell_chk #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .bias_i(bias_i), .commit_i(commit_i),
  .relu_en_i(relu_en_i), .acc_q(acc_q), .y_o(y_o), .y_valid_o(y_valid_o)
);

// File: tb/test_sat_mac_cell.sv
module test_sat_mac_cell;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr_i = 1'b0, acc_en_i = 1'b0, commit_i = 1'b0, relu_en_i = 1'b0;
  logic [15:0] bias_i = '0, x_i = '0, w_i = '0;
  logic [15:0] y_o;
  logic        y_valid_o;
  int          checks = 0, errors = 0;

  // bias, x, w, repeat count, relu, expected
  localparam logic [15:0] T_BIAS [NV] = '{16'h0100, 16'h0000, 16'h0000, 16'h0100, 16'h0000, 16'h0005,
    16'h0000, 16'h0000, 16'h0000, 16'h7FFF, 16'h8000, 16'h7FF0, 16'h8000};
  localparam logic [15:0] T_X [NV] = '{16'h0200, 16'h0100, 16'h0100, 16'hFF00, 16'hFFFF, 16'h0001,
    16'h7FFF, 16'h8000, 16'h8000, 16'h0100, 16'hFFFF, 16'h0100, 16'h0000};
  localparam logic [15:0] T_W [NV] = '{16'h0180, 16'hFF00, 16'hFF00, 16'h0080, 16'h0001, 16'h0001,
    16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h0001, 16'h0001, 16'h0001, 16'h0000};
  localparam int T_N [NV] = '{1, 3, 3, 1, 1, 1, 1, 1, 1, 1, 1, 15, 0};
  localparam logic T_RELU [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
  // R3 R6 R7 R8 R9: basic, negative, rectified, floor, truncation, clamps, exact edges
  localparam logic [15:0] T_EXP [NV] = '{16'h0400, 16'hFD00, 16'h0000, 16'h0080, 16'hFFFF, 16'h0005,
    16'h7FFF, 16'h8000, 16'h0000, 16'h7FFF, 16'h8000, 16'h7FFF, 16'h0000};

  sat_mac_cell i_sat_mac_cell (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .bias_i(bias_i), .acc_en_i(acc_en_i),
    .x_i(x_i), .w_i(w_i), .commit_i(commit_i), .relu_en_i(relu_en_i),
    .y_o(y_o), .y_valid_o(y_valid_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_clear(input logic [15:0] b);
    clr_i = 1'b1; bias_i = b;
    @(negedge clk);
    clr_i = 1'b0;
  endtask

  task automatic do_acc(input logic [15:0] x, input logic [15:0] w, input int n);
    x_i = x; w_i = w;
    for (int i = 0; i < n; i++) begin
      acc_en_i = 1'b1;
      @(negedge clk);
    end
    acc_en_i = 1'b0;
  endtask

  task automatic do_commit(input logic r);
    commit_i = 1'b1; relu_en_i = r;
    @(negedge clk);
    commit_i = 1'b0; relu_en_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset y_o", y_o, 16'h0000);
    check("R1 reset y_valid_o", {15'b0, y_valid_o}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    do_commit(1'b0);
    check("R1 accumulator zero after reset", y_o, 16'h0000);

    for (int v = 0; v < NV; v++) begin
      do_clear(T_BIAS[v]);
      do_acc(T_X[v], T_W[v], T_N[v]);
      do_commit(T_RELU[v]);
      check($sformatf("R3 R6 R7 R8 R9 table vector %0d", v), y_o, T_EXP[v]);
      check($sformatf("R5 valid after commit vector %0d", v), {15'b0, y_valid_o}, 16'h0001);
    end
    @(negedge clk);
    check("R5 valid drops after one cycle", {15'b0, y_valid_o}, 16'h0000);
    check("R5 output held", y_o, 16'h0000);

    do_clear(16'h0010);
    do_acc(16'h0100, 16'h0100, 4);
    do_commit(1'b0);
    check("R3 partial sum", y_o, 16'h0410);
    x_i = 16'h0100; w_i = 16'h0100; acc_en_i = 1'b1;
    do_clear(16'h0020);
    acc_en_i = 1'b0;
    do_commit(1'b0);
    check("R2 clear discards sum and wins over accumulate", y_o, 16'h0020);
    do_commit(1'b0);
    check("R10 commit leaves accumulator unchanged", y_o, 16'h0020);
    acc_en_i = 1'b1; x_i = 16'h0100; w_i = 16'h0100;
    do_commit(1'b0);
    acc_en_i = 1'b0;
    check("R10 commit sees value before same-cycle add", y_o, 16'h0020);
    do_commit(1'b0);
    check("R10 same-cycle add landed", y_o, 16'h0120);
    for (int i = 0; i < 4; i++) begin
      x_i = 16'h7FFF - 16'(i); w_i = 16'h4000 + 16'(i);
      @(negedge clk);
    end
    check("R5 y_o held without commit", y_o, 16'h0120);
    do_commit(1'b0);
    check("R3 inputs ignored with accumulate low", y_o, 16'h0120);

    do_clear(16'h7FFF);
    do_acc(16'h8000, 16'h8000, 511);
    do_commit(1'b0);
    check("R4 R7 large sum below wrap clamps high", y_o, 16'h7FFF);
    do_acc(16'h8000, 16'h8000, 1);
    do_commit(1'b0);
    check("R4 R8 sum wrapped past 2^31 clamps low", y_o, 16'h8000);
    do_commit(1'b1);
    check("R4 R9 wrapped negative rectified", y_o, 16'h0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule